// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Not-Recently-Used Replacement

This block holds recently used virtual-to-physical page translations for a memory pipeline. Every cycle it can accept one lookup, made of a virtual page number, a page offset and an access kind (load, store or instruction fetch). The page number is compared against the tags of all entries in parallel. One cycle later the block reports one of three outcomes: a hit with the translated physical address, a miss, or a protection violation. A violation means the page is present but its rights forbid the access.

Each entry carries a valid flag, a tag, a physical page number, read and write rights, a referenced flag and a modified (dirty) flag. Successful lookups mark their entry as referenced, and successful stores also mark it as modified. A programmable lookup counter clears every referenced flag each time it wraps, so the flags approximate recent use. A page walker outside the block installs translations through the refill port. That port always shows which slot the next install will overwrite and whether that slot holds a modified page, so the walker can arrange a write-back. A flush input empties the whole buffer.

Top module: `tlb_nru`

## Requirements
- R1: A lookup strobed in cycle t gives `rsp_valid` high in cycle t+1 with exactly one of `rsp_hit`, `rsp_miss`, `rsp_viol` high. With no lookup, all four are low in the following cycle.
- R2: A translation installed in any slot hits for its virtual page number and returns its own physical page number. A page number held by no valid slot gives a miss.
- R3: On a hit, `rsp_paddr` equals the physical page number in the upper bits and the untranslated `lk_off` in the low OFF_W bits. On a miss or violation it is zero.
- R4: Access codes are 0 = load, 1 = store, 2 = fetch. A store needs the write right, and a load or fetch needs the read right. A present page without the needed right gives `rsp_viol` instead of a hit, and leaves that slot's referenced and modified flags unchanged.
- R5: A store hit marks the slot modified. `rf_vic_dirty` is high when the current victim slot is valid and modified.
- R6: A hit marks its slot referenced. The victim is the lowest-indexed invalid slot if one exists, and otherwise the lowest-indexed slot that is not referenced.
- R7: If all slots are valid and referenced, the victim is slot 0, and an install there clears the referenced flags of all other slots.
- R8: With `clr_period` = N > 0, every Nth lookup clears all referenced flags, except the flag of a slot hit by that same lookup, which ends set. N = 0 disables the clearing.
- R9: An installed slot starts valid, referenced and not modified, with the rights given on the refill port.
- R10: `flush` invalidates every slot. Later lookups miss, and the victim returns to slot 0 with `rf_vic_dirty` low.
- R11: After reset all slots are invalid, no response is shown, and the victim is slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every slot |
| clr_period | input | CNT_W | Lookups between referenced-flag clears, 0 = never |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_off | input | OFF_W | Lookup page offset |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No valid slot matched |
| rsp_viol | output | 1 | Slot matched but rights forbid the access |
| rsp_paddr | output | PPN_W+OFF_W | Physical address on a hit |
| rf_valid | input | 1 | Install strobe |
| rf_vpn | input | VPN_W | Virtual page number to install |
| rf_ppn | input | PPN_W | Physical page number to install |
| rf_rd | input | 1 | Read right of the new slot |
| rf_wr | input | 1 | Write right of the new slot |
| rf_victim | output | $clog2(ENTRIES) | Slot the next install overwrites |
| rf_vic_dirty | output | 1 | Victim slot is valid and modified |

## Verification
The bench targets the cases where the replacement order can go quietly wrong. It runs the all-referenced wrap, where a design that forgets to clear the other flags would evict slot 0 again and again. It runs a periodic clear that lands on the same lookup as a hit, where a wrong clear-versus-set priority would make the just-used slot the next victim. It checks that a rights violation leaves the flags alone, since a design that marks the slot anyway would protect a page that was never used and would flag a clean page for write-back. It also checks that every offset passes through untranslated and that a flush resets the victim choice.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  // Stores need the write right; loads, fetches and the spare code need read.
  function automatic logic rights_allow(acc_e acc, logic rd, logic wr);
    return (acc == ACC_STORE) ? wr : rd;
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [VPN_W-1:0]              key,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0]            vld,
  output logic                          found,
  output logic [IDX_W-1:0]              idx
);

  logic [ENTRIES-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq[g] = vld[g] && (tags[g] == key);
    end
  endgenerate

  // Lowest index wins if software ever installs a duplicate.
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

  assign found = |eq;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld,
  input  logic [ENTRIES-1:0] refd,
  output logic [IDX_W-1:0]   idx,
  output logic               wrap
);

  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] cold_idx;
  logic             any_free;
  logic             any_cold;

  always_comb begin
    free_idx = '0;
    cold_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i])  free_idx = IDX_W'(i);
      if (!refd[i]) cold_idx = IDX_W'(i);
    end
  end

  assign any_free = ~&vld;
  assign any_cold = ~&refd;

  always_comb begin
    wrap = 1'b0;
    if (any_free)      idx = free_idx;
    else if (any_cold) idx = cold_idx;
    else begin
      idx  = '0;
      wrap = 1'b1;
    end
  end

endmodule

// File: rtl/tlb_ref_timer.sv
module tlb_ref_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             tick,
  output logic             clear
);

  logic [CNT_W-1:0] cnt;

  assign clear = tick && (period != '0) && (cnt >= period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || period == '0) cnt <= '0;
    else if (tick) cnt <= clear ? '0 : cnt + CNT_W'(1);
  end

endmodule

// File: rtl/tlb_nru.sv
module tlb_nru
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int OFF_W   = 12,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [CNT_W-1:0] clr_period,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [OFF_W-1:0] lk_off,
  input  logic [1:0]       lk_acc,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_viol,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PPN_W-1:0] rf_ppn,
  input  logic             rf_rd,
  input  logic             rf_wr,
  output logic [IDX_W-1:0] rf_victim,
  output logic             rf_vic_dirty
);

  // Per-slot state
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0]            vld_q, ref_q, dirty_q, rd_q, wr_q;
  logic [ENTRIES-1:0]            vld_d, ref_d, dirty_d;

  // Lookup path
  logic             m_found;
  logic [IDX_W-1:0] m_idx;
  logic             allow;
  logic             hit_now, viol_now, miss_now;
  logic             tmr_clr;
  logic             vic_wrap;
  acc_e             acc;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .key   (lk_vpn),
    .tags  (tag_q),
    .vld   (vld_q),
    .found (m_found),
    .idx   (m_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .vld  (vld_q),
    .refd (ref_q),
    .idx  (rf_victim),
    .wrap (vic_wrap)
  );

  tlb_ref_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .period (clr_period),
    .tick   (lk_valid),
    .clear  (tmr_clr)
  );

  assign acc      = acc_e'(lk_acc);
  assign allow    = rights_allow(acc, rd_q[m_idx], wr_q[m_idx]);
  assign hit_now  = lk_valid && m_found && allow;
  assign viol_now = lk_valid && m_found && !allow;
  assign miss_now = lk_valid && !m_found;

  assign rf_vic_dirty = vld_q[rf_victim] && dirty_q[rf_victim];

  // Flag next state: clears first, then the hit, then an install, then flush.
  always_comb begin
    vld_d   = vld_q;
    ref_d   = ref_q;
    dirty_d = dirty_q;
    if (tmr_clr) ref_d = '0;
    if (rf_valid && vic_wrap) ref_d = '0;
    if (hit_now) begin
      ref_d[m_idx] = 1'b1;
      if (acc == ACC_STORE) dirty_d[m_idx] = 1'b1;
    end
    if (rf_valid) begin
      vld_d[rf_victim]   = 1'b1;
      ref_d[rf_victim]   = 1'b1;
      dirty_d[rf_victim] = 1'b0;
    end
    if (flush) begin
      vld_d   = '0;
      ref_d   = '0;
      dirty_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
    end else begin
      vld_q   <= vld_d;
      ref_q   <= ref_d;
      dirty_q <= dirty_d;
    end
  end

  // Payload fields carry no reset; only the valid flag qualifies them.
  always_ff @(posedge clk) begin
    if (rf_valid) begin
      tag_q[rf_victim] <= rf_vpn;
      ppn_q[rf_victim] <= rf_ppn;
      rd_q[rf_victim]  <= rf_rd;
      wr_q[rf_victim]  <= rf_wr;
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_viol  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= hit_now;
      rsp_miss  <= miss_now;
      rsp_viol  <= viol_now;
      rsp_paddr <= hit_now ? {ppn_q[m_idx], lk_off} : '0;
    end
  end

endmodule

// File: rtl/tlb_nru_chk.sv
module tlb_nru_chk #(
  parameter int OFF_W = 12,
  parameter int PA_W  = 30,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             lk_valid,
  input logic [OFF_W-1:0] lk_off,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_viol,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rf_valid,
  input logic [IDX_W-1:0] rf_victim,
  input logic             rf_vic_dirty
);

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst) lk_valid |=> rsp_valid); // R1
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> !rsp_valid); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_viol}) == 1); // R1
  AST_QUIET: assert property (@(posedge clk) disable iff (rst) !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_viol)); // R1
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst) lk_valid |=> (!rsp_hit || rsp_paddr[OFF_W-1:0] == $past(lk_off))); // R3
  AST_NOHIT_ZERO: assert property (@(posedge clk) disable iff (rst) !rsp_hit |-> rsp_paddr == '0); // R3
  AST_FLUSH_MISS: assert property (@(posedge clk) disable iff (rst) (flush && !rf_valid) ##1 (lk_valid && !rf_valid) |=> rsp_miss); // R10
  AST_FLUSH_VICTIM: assert property (@(posedge clk) disable iff (rst) (flush && !rf_valid) |=> (rf_victim == '0 && !rf_vic_dirty)); // R10

endmodule

bind tlb_nru tlb_nru_chk #(.OFF_W(OFF_W), .PA_W(PA_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .lk_valid     (lk_valid),
  .lk_off       (lk_off),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss     (rsp_miss),
  .rsp_viol     (rsp_viol),
  .rsp_paddr    (rsp_paddr),
  .rf_valid     (rf_valid),
  .rf_victim    (rf_victim),
  .rf_vic_dirty (rf_vic_dirty)
);

// File: tb/tlb_nru_tb.sv
`timescale 1ns/1ps
module tlb_nru_tb;

  localparam int ENTRIES = 4;
  localparam int VPN_W   = 8;
  localparam int PPN_W   = 6;
  localparam int OFF_W   = 4;
  localparam int CNT_W   = 4;
  localparam int IDX_W   = 2;
  localparam int PA_W    = PPN_W + OFF_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic [CNT_W-1:0] clr_period = '0;
  logic             lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic [OFF_W-1:0] lk_off = '0;
  logic [1:0]       lk_acc = '0;
  logic             rsp_valid, rsp_hit, rsp_miss, rsp_viol;
  logic [PA_W-1:0]  rsp_paddr;
  logic             rf_valid = 1'b0;
  logic [VPN_W-1:0] rf_vpn = '0;
  logic [PPN_W-1:0] rf_ppn = '0;
  logic             rf_rd = 1'b0, rf_wr = 1'b0;
  logic [IDX_W-1:0] rf_victim;
  logic             rf_vic_dirty;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [VPN_W-1:0] e_vpn [ENTRIES];
  logic [PPN_W-1:0] e_ppn [ENTRIES];
  logic             e_rd  [ENTRIES];
  logic             e_wr  [ENTRIES];

  always #5 clk = ~clk;

  tlb_nru #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .clr_period(clr_period),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_acc(lk_acc),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_viol(rsp_viol),
    .rsp_paddr(rsp_paddr), .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_victim(rf_victim), .rf_vic_dirty(rf_vic_dirty)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Lookup driven at a falling edge; the registered response is read one cycle later.
  task automatic lookup(logic [VPN_W-1:0] vpn, logic [OFF_W-1:0] off, logic [1:0] acc,
                        output logic [3:0] res, output logic [PA_W-1:0] pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = vpn; lk_off = off; lk_acc = acc;
    @(negedge clk);
    lk_valid = 1'b0;
    res = {rsp_valid, rsp_hit, rsp_miss, rsp_viol};
    pa  = rsp_paddr;
  endtask

  // Expected response for slot e: {valid, hit, miss, viol}.
  task automatic lookup_slot(string req, int e, logic [OFF_W-1:0] off, logic [1:0] acc);
    logic [3:0]      res;
    logic [PA_W-1:0] pa;
    logic            ok;
    ok = (acc == 2'd1) ? e_wr[e] : e_rd[e];
    lookup(e_vpn[e], off, acc, res, pa);
    check(req, "outcome", {28'd0, res}, {28'd0, 1'b1, ok, 1'b0, !ok});
    check("R3", "paddr", {22'd0, pa}, ok ? {22'd0, e_ppn[e], off} : 32'd0);
  endtask

  task automatic lookup_miss(string req, logic [VPN_W-1:0] vpn);
    logic [3:0]      res;
    logic [PA_W-1:0] pa;
    lookup(vpn, 4'h3, 2'd0, res, pa);
    check(req, "miss outcome", {28'd0, res}, 32'b1010);
    check("R3", "miss paddr", {22'd0, pa}, 32'd0);
  endtask

  task automatic refill(string req, logic [VPN_W-1:0] vpn, logic [PPN_W-1:0] ppn, logic rd, logic wr,
                        int exp_vic, logic exp_dirty);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = vpn; rf_ppn = ppn; rf_rd = rd; rf_wr = wr;
    #1;
    check(req, "victim", {30'd0, rf_victim}, exp_vic);
    check(req, "victim dirty", {31'd0, rf_vic_dirty}, {31'd0, exp_dirty});
    e_vpn[exp_vic] = vpn; e_ppn[exp_vic] = ppn; e_rd[exp_vic] = rd; e_wr[exp_vic] = wr;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic peek_victim(string req, int exp_vic, logic exp_dirty);
    @(negedge clk);
    check(req, "victim", {30'd0, rf_victim}, exp_vic);
    check(req, "victim dirty", {31'd0, rf_vic_dirty}, {31'd0, exp_dirty});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R11", "victim", {30'd0, rf_victim}, 32'd0);
    check("R11", "victim dirty", {31'd0, rf_vic_dirty}, 32'd0);
    lookup_miss("R11", 8'h05);

    // R6 invalid slots are chosen first, in index order; R9 installs
    for (int i = 0; i < ENTRIES; i++)
      refill("R6", VPN_W'(i * 37 + 5), PPN_W'(6'h11 + i * 9), (i != 2), (i != 1), i, 1'b0);

    // R2 R3 R4 sweep: every slot, every access kind, every offset
    for (int e = 0; e < ENTRIES; e++)
      for (int a = 0; a < 3; a++)
        for (int o = 0; o < 16; o++)
          lookup_slot((a == 1) ? "R4" : "R2", e, OFF_W'(o), 2'(a));
    lookup_miss("R2", 8'hFF);
    lookup_miss("R2", 8'h00);

    // R7 all slots referenced: slot 0 is evicted, and it was written (R5)
    peek_victim("R5", 0, 1'b1);
    refill("R7", 8'h99, 6'h3F, 1'b1, 1'b0, 0, 1'b1);
    lookup_miss("R2", 8'h05);
    // slot 1 saw only a refused store, so it is clean (R4, R5)
    peek_victim("R7", 1, 1'b0);
    lookup_slot("R6", 1, 4'h7, 2'd0);
    peek_victim("R6", 2, 1'b1);
    lookup_slot("R4", 2, 4'h1, 2'd0);   // refused load must not mark slot 2
    peek_victim("R4", 2, 1'b1);
    lookup_slot("R4", 0, 4'h2, 2'd1);   // refused store must not dirty slot 0

    // R8 periodic clear every 3 lookups, coinciding with a hit on slot 3
    @(negedge clk);
    clr_period = 4'd3;
    lookup_miss("R8", 8'hFE);
    lookup_miss("R8", 8'hFD);
    peek_victim("R8", 2, 1'b1);
    lookup_slot("R8", 3, 4'hA, 2'd2);
    peek_victim("R9", 0, 1'b0);
    @(negedge clk);
    clr_period = 4'd0;
    lookup_slot("R8", 0, 4'h4, 2'd0);
    lookup_slot("R8", 1, 4'h5, 2'd2);
    lookup_slot("R8", 2, 4'h6, 2'd1);
    peek_victim("R8", 0, 1'b0);  // slot 3 kept its flag through the clear
    lookup_slot("R8", 3, 4'h8, 2'd0);
    peek_victim("R8", 0, 1'b0);  // counter disabled: nothing cleared

    // R10 flush
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < ENTRIES; i++) lookup_miss("R10", e_vpn[i]);
    peek_victim("R10", 0, 1'b0);
    refill("R9", 8'h42, 6'h2B, 1'b1, 1'b1, 0, 1'b0);
    lookup_slot("R9", 0, 4'hC, 2'd1);
    peek_victim("R9", 1, 1'b0);

    finish_run();
  end

endmodule